// File: doc/BRIEF.md
# Time-Shared Two-Channel Hysteresis Switch

This block turns a stream of signed field samples from one shared converter into two latched, active-low switch outputs. The converter serves channel A and channel B in alternating slots of fixed length. The block tells the converter which channel to present through `chan_sel` and marks the last cycle of every slot with `slot_tick`. Only at that tick does the channel that owns the slot compare its sample against its own pair of thresholds. A sample strictly above the operate level turns the output on (driven low). A sample strictly below the release level turns it off (driven high). A sample anywhere between the two levels leaves the output as it was.

After reset a blanking interval forces both outputs on, whatever field is presented. When the interval ends, each channel starts from the on state and changes only at the end of its own next slot. A field that crosses a threshold while the other channel holds the converter has no effect unless it is still beyond that threshold at the end of the owning channel's slot.

Three state machines make up the block, and each has named states and transitions:
- The slot sequencer has two states, `CH_A` and `CH_B`. The transition `SLOT_END` (slot_tick high) moves it to the other state.
- The power-up sequencer has two states, `PW_BLANK` and `PW_RUN`. The transition `BLANK_DONE` fires when the blanking count reaches its last value; `PW_RUN` is left only by reset.
- Each channel latch has two states, `LT_ON` and `LT_OFF`. The transition `TRIP` goes from `LT_OFF` to `LT_ON` and the transition `RELEASE` goes from `LT_ON` to `LT_OFF`. Both fire only on an update strobe.

Top module: `dual_hyst_latch`

## Requirements
- R1: After reset `chan_sel` is 0 (channel A; 1 means channel B). Each slot lasts SLOT_CYC cycles. `slot_tick` is high on the last cycle of each slot, and `chan_sel` flips on the cycle after it.
- R2: An output changes only in the cycle that follows a `slot_tick` of its own channel, and only when the blanking interval is over. A field excursion that reverts before the end of the slot leaves the output unchanged.
- R3: When the sample present at the owning slot's tick is strictly greater than that channel's operate level, the output is low from the next cycle on.
- R4: When the sample present at the owning slot's tick is strictly less than that channel's release level, the output is high from the next cycle on.
- R5: A sample at the tick that lies between the release and operate levels, both ends included, leaves the output unchanged.
- R6: For the first PON_CYC cycles after reset is released, both outputs are low whatever the field is.
- R7: At the end of blanking both channels are in the on state, so an in-band field keeps both outputs low.
- R8: A crossing that occurs while the other channel owns the converter and reverts before the owning channel's next tick does not change the output.
- R9: `cfg_err` is high whenever a channel's operate level is not greater than its release level. A channel configured that way ignores its samples and holds its output.
- R10: Asserting `rst` while running restarts blanking (outputs low) and restarts the slot sequence at channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| field_sample | input | SAMPLE_W | Signed sample of the channel named by chan_sel |
| op_a | input | SAMPLE_W | Signed operate level, channel A |
| rel_a | input | SAMPLE_W | Signed release level, channel A |
| op_b | input | SAMPLE_W | Signed operate level, channel B |
| rel_b | input | SAMPLE_W | Signed release level, channel B |
| chan_sel | output | 1 | Channel owning the current slot (0 = A, 1 = B) |
| slot_tick | output | 1 | High on the last cycle of each slot |
| out_a_n | output | 1 | Channel A switch, low = on |
| out_b_n | output | 1 | Channel B switch, low = on |
| cfg_err | output | 1 | Operate level not above release level on some channel |

## Verification
A slot sequencer that is out of step shows up within one slot as a `slot_tick` or `chan_sel` in the wrong cycle. Because the bench routes field A or field B onto the shared sample port according to `chan_sel`, such a fault also feeds the wrong channel's field into a latch. A latch in the wrong state shows at its output pin on the very next cycle once blanking has ended. An error in the power-up sequencer shows as outputs released early or held low too long, visible at the first cycle past PON_CYC. The random phase keeps fields close to the thresholds, including exactly equal to them, so that an off-by-one in any comparison appears within a few slots.

// File: rtl/dhl_pkg.sv
package dhl_pkg;

    // Slot owner; the value is also the chan_sel encoding (0 = A, 1 = B).
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // Power-up sequencing.
    typedef enum logic {
        PW_BLANK = 1'b0,
        PW_RUN   = 1'b1
    } pwr_e;

    // Latched switch state of one channel.
    typedef enum logic {
        LT_OFF = 1'b0,
        LT_ON  = 1'b1
    } latch_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/dhl_slot_seq.sv
module dhl_slot_seq
    import dhl_pkg::*;
#(
    parameter int SLOT_CYC = 800
) (
    input  logic  clk,
    input  logic  rst,
    output chan_e chan,
    output logic  tick
);

    localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    chan_e         st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CH_A;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: SLOT_END toggles the owner
    always_comb begin
        st_d  = st_q;
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        unique case (st_q)
            CH_A: if (cnt_q == LAST) st_d = CH_B;
            CH_B: if (cnt_q == LAST) st_d = CH_A;
        endcase
    end

    // outputs
    always_comb begin
        chan = st_q;
        tick = (cnt_q == LAST);
    end

    assert_owner_flip_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (chan != $past(chan)))
        else $error("owner did not change after slot end");

    assert_owner_steady_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(chan))
        else $error("owner changed inside a slot");

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick)
        else $error("consecutive slot ticks");

endmodule

// File: rtl/dhl_pon_fsm.sv
module dhl_pon_fsm
    import dhl_pkg::*;
#(
    parameter int PON_CYC = 1600
) (
    input  logic clk,
    input  logic rst,
    output logic blank
);

    localparam int CW = (PON_CYC > 1) ? $clog2(PON_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PON_CYC - 1);

    pwr_e          st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PW_BLANK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: BLANK_DONE after PON_CYC cycles, RUN is terminal
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PW_BLANK: begin
                if (cnt_q == LAST) st_d = PW_RUN;
                else               cnt_d = cnt_q + 1'b1;
            end
            PW_RUN: st_d = PW_RUN;
        endcase
    end

    // output
    always_comb begin
        blank = (st_q == PW_BLANK);
    end

    assert_run_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == PW_RUN) |=> (st_q == PW_RUN))
        else $error("left run state without reset");

    assert_blank_early_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == PW_BLANK && cnt_q != LAST) |=> (st_q == PW_BLANK))
        else $error("blanking ended early");

endmodule

// File: rtl/dhl_chan_latch.sv
module dhl_chan_latch
    import dhl_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [SAMPLE_W-1:0] op_lvl,
    input  logic signed [SAMPLE_W-1:0] rel_lvl,
    output logic                       on,
    output logic                       bad_cfg
);

    latch_e st_q, st_d;
    logic   cfg_ok;

    assign cfg_ok = (op_lvl > rel_lvl);

    // state register; power-up state is on
    always_ff @(posedge clk) begin
        if (rst) st_q <= LT_ON;
        else     st_q <= st_d;
    end

    // next state: TRIP and RELEASE only on an update strobe
    always_comb begin
        st_d = st_q;
        if (upd && cfg_ok) begin
            unique case (st_q)
                LT_OFF: if (sample > op_lvl)  st_d = LT_ON;
                LT_ON:  if (sample < rel_lvl) st_d = LT_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        on      = (st_q == LT_ON);
        bad_cfg = !cfg_ok;
    end

    assert_hold_no_upd_R2: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(on))
        else $error("latch moved without update strobe");

    assert_trip_R3: assert property (@(posedge clk) disable iff (rst)
        (upd && !bad_cfg && sample > op_lvl) |=> on)
        else $error("latch not on above operate level");

    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        (upd && !bad_cfg && sample < rel_lvl) |=> !on)
        else $error("latch not off below release level");

    assert_band_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && sample >= rel_lvl && sample <= op_lvl) |=> $stable(on))
        else $error("latch moved inside hysteresis band");

    assert_bad_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (upd && bad_cfg) |=> $stable(on))
        else $error("misconfigured channel changed state");

endmodule

// File: rtl/dual_hyst_latch.sv
module dual_hyst_latch
    import dhl_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int SLOT_CYC = 800,
    parameter int PON_CYC  = 1600
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] field_sample,
    input  logic signed [SAMPLE_W-1:0] op_a,
    input  logic signed [SAMPLE_W-1:0] rel_a,
    input  logic signed [SAMPLE_W-1:0] op_b,
    input  logic signed [SAMPLE_W-1:0] rel_b,
    output logic                       chan_sel,
    output logic                       slot_tick,
    output logic                       out_a_n,
    output logic                       out_b_n,
    output logic                       cfg_err
);

    chan_e                      owner;
    logic                       tick;
    logic                       blank;
    logic [NUM_CH-1:0]          own;
    logic [NUM_CH-1:0]          upd;
    logic [NUM_CH-1:0]          lat_on;
    logic [NUM_CH-1:0]          bad;
    logic signed [SAMPLE_W-1:0] op_v  [NUM_CH];
    logic signed [SAMPLE_W-1:0] rel_v [NUM_CH];

    assign op_v[0]  = op_a;
    assign rel_v[0] = rel_a;
    assign op_v[1]  = op_b;
    assign rel_v[1] = rel_b;
    assign own[0]   = (owner == CH_A);
    assign own[1]   = (owner == CH_B);

    dhl_slot_seq #(.SLOT_CYC(SLOT_CYC)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .chan (owner),
        .tick (tick)
    );

    dhl_pon_fsm #(.PON_CYC(PON_CYC)) u_pon (
        .clk   (clk),
        .rst   (rst),
        .blank (blank)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign upd[g] = tick && own[g] && !blank;

        dhl_chan_latch #(.SAMPLE_W(SAMPLE_W)) u_lat (
            .clk     (clk),
            .rst     (rst),
            .upd     (upd[g]),
            .sample  (field_sample),
            .op_lvl  (op_v[g]),
            .rel_lvl (rel_v[g]),
            .on      (lat_on[g]),
            .bad_cfg (bad[g])
        );
    end

    // outputs: forced on while blanking, else the latched state
    always_comb begin
        chan_sel  = owner;
        slot_tick = tick;
        out_a_n   = blank ? 1'b0 : !lat_on[0];
        out_b_n   = blank ? 1'b0 : !lat_on[1];
        cfg_err   = |bad;
    end

    assert_one_upd_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd))
        else $error("both channels updated in one cycle");

    assert_a_change_R2: assert property (@(posedge clk) disable iff (rst)
        (!blank && !(tick && owner == CH_A)) |=> $stable(out_a_n))
        else $error("output A changed outside its slot end");

    assert_b_change_R2: assert property (@(posedge clk) disable iff (rst)
        (!blank && !(tick && owner == CH_B)) |=> $stable(out_b_n))
        else $error("output B changed outside its slot end");

endmodule

// File: tb/sim_dual_hyst_latch.sv
module sim_dual_hyst_latch;

    localparam int W = 12;
    localparam int S = 8;
    localparam int P = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic signed [W-1:0] fa, fb, op_a, rel_a, op_b, rel_b;
    logic signed [W-1:0] field_sample;
    logic chan_sel, slot_tick, out_a_n, out_b_n, cfg_err;

    // bench-side mux standing in for the shared converter
    assign field_sample = chan_sel ? fb : fa;

    dual_hyst_latch #(.SAMPLE_W(W), .SLOT_CYC(S), .PON_CYC(P)) u0 (
        .clk(clk), .rst(rst), .field_sample(field_sample),
        .op_a(op_a), .rel_a(rel_a), .op_b(op_b), .rel_b(rel_b),
        .chan_sel(chan_sel), .slot_tick(slot_tick),
        .out_a_n(out_a_n), .out_b_n(out_b_n), .cfg_err(cfg_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string ctx = "R1";

    // reference model, advanced on each rising edge
    int   m_cnt, m_pon;
    logic m_chan;
    logic [1:0] m_on;

    function automatic logic next_on(logic cur, logic signed [W-1:0] s,
                                     logic signed [W-1:0] op, logic signed [W-1:0] rl);
        if (!(op > rl)) return cur;
        if (s > op)     return 1'b1;
        if (s < rl)     return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pon = 0; m_chan = 1'b0; m_on = 2'b11;
        end else begin
            if (m_cnt == S-1 && m_pon >= P) begin
                if (!m_chan) m_on[0] = next_on(m_on[0], fa, op_a, rel_a);
                else         m_on[1] = next_on(m_on[1], fb, op_b, rel_b);
            end
            if (m_cnt == S-1) begin m_cnt = 0; m_chan = !m_chan; end
            else m_cnt = m_cnt + 1;
            if (m_pon < P) m_pon = m_pon + 1;
        end
    end

    task automatic chk(logic got, logic exp, string tag, string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all();
        logic blank_now;
        string otag;
        blank_now = (m_pon < P);
        otag = blank_now ? "R6" : ctx;
        chk(slot_tick, (m_cnt == S-1), "R1", "slot_tick");
        chk(chan_sel, m_chan, "R1", "chan_sel");
        chk(cfg_err, !(op_a > rel_a) || !(op_b > rel_b), "R9", "cfg_err");
        chk(out_a_n, blank_now ? 1'b0 : !m_on[0], otag, "out_a_n");
        chk(out_b_n, blank_now ? 1'b0 : !m_on[1], otag, "out_b_n");
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge clk);
            check_all();
        end
    endtask

    // advance until the first cycle of a slot owned by channel ch
    task automatic to_slot_start(logic ch);
        do cyc(1); while (!(slot_tick && chan_sel != ch));
        cyc(1);
    endtask

    function automatic logic signed [W-1:0] pick(logic signed [W-1:0] op,
                                                  logic signed [W-1:0] rl);
        int r;
        r = $urandom % 5;
        case (r)
            0: return op + W'(1 + $urandom % 40);
            1: return rl - W'(1 + $urandom % 40);
            2: return (op > rl) ? rl + W'($urandom % (op - rl + 1)) : '0;
            3: return op;
            default: return rl;
        endcase
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        op_a = 17; rel_a = -17; op_b = 17; rel_b = -17;
        fa = 0; fb = 0;

        // reset state
        ctx = "R1";
        cyc(3);
        chk(chan_sel, 1'b0, "R1", "reset chan_sel");
        chk(out_a_n, 1'b0, "R6", "reset out_a_n");

        // blanking with fields far below release
        @(negedge clk); rst = 1'b0;
        fa = -300; fb = -300;
        ctx = "R6";
        cyc(P - 2);
        chk(out_a_n, 1'b0, "R6", "blank out_a_n");
        chk(out_b_n, 1'b0, "R6", "blank out_b_n");

        // in-band at blank end: stays on
        fa = 5; fb = -5;
        ctx = "R7";
        cyc(3 * S);
        chk(out_a_n, 1'b0, "R7", "in-band after blank A");
        chk(out_b_n, 1'b0, "R7", "in-band after blank B");

        // trip and release
        ctx = "R4";
        fb = -100;
        cyc(2 * S);
        chk(out_b_n, 1'b1, "R4", "B released");
        fa = -18;
        cyc(2 * S);
        chk(out_a_n, 1'b1, "R4", "A released at rel-1");
        ctx = "R3";
        fa = 18;
        cyc(2 * S);
        chk(out_a_n, 1'b0, "R3", "A on at op+1");

        // exact thresholds are inside the band
        ctx = "R5";
        fa = -17; fb = 17;
        cyc(2 * S);
        chk(out_a_n, 1'b0, "R5", "A holds at rel");
        chk(out_b_n, 1'b1, "R5", "B holds at op");

        // excursion of A during B's slot, reverting before A's tick
        ctx = "R8";
        fa = 0;
        to_slot_start(1'b1);
        fa = -200;
        cyc(S - 2);
        fa = 0;
        cyc(2 * S);
        chk(out_a_n, 1'b0, "R8", "A ignores foreign-slot excursion");

        // excursion inside A's own slot that reverts before its tick
        ctx = "R2";
        to_slot_start(1'b0);
        fa = -200;
        cyc(S - 2);
        fa = 0;
        cyc(2 * S);
        chk(out_a_n, 1'b0, "R2", "A ignores mid-slot excursion");

        // misconfigured channel holds
        ctx = "R9";
        op_a = 0; rel_a = 0; fa = -200;
        cyc(3 * S);
        chk(cfg_err, 1'b1, "R9", "cfg_err raised");
        chk(out_a_n, 1'b0, "R9", "A holds when misconfigured");
        op_a = 17; rel_a = -17; fa = 0;
        cyc(2);

        // reset mid-run
        ctx = "R10";
        fb = -100;
        cyc(2 * S);
        @(negedge clk); rst = 1'b1;
        cyc(2);
        chk(chan_sel, 1'b0, "R10", "chan_sel after reset");
        chk(out_b_n, 1'b0, "R10", "out_b_n after reset");
        @(negedge clk); rst = 1'b0;
        cyc(P + 2 * S);

        // random phase
        ctx = "R3 R4 R5";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 40 == 0) begin
                op_a  = W'($urandom % 60);  rel_a = -W'($urandom % 60);
                op_b  = W'($urandom % 60);  rel_b = -W'($urandom % 60);
            end
            fa = pick(op_a, rel_a);
            fb = pick(op_b, rel_b);
            cyc(1 + $urandom % 6);
        end

        summary();
        $finish;
    end

endmodule